// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block translates a 64-bit virtual address into a 32-bit physical address through a fully associative table of page-pair mappings. Each slot holds a virtual page-pair number that includes the two address-region bits. It also holds a page-size mask, an address-space tag, a global flag, and two physical frame numbers. Each frame number carries its own valid flag and its own writable (dirty) flag. The lower frame serves the even page of the pair and the upper frame serves the odd page.

The lookup is purely combinational. The caller presents an address, an access kind (load or store) and the current address-space tag. In the same cycle the block returns a physical address, the index of the winning slot, and a two-bit result code. A synchronous write port loads a whole slot in one clock edge and makes it eligible for matching. Reset makes every slot ineligible.

Top module: `tlb_xlate`

## Requirements
- R1: After reset, and before any slot is written, every lookup returns err=1 (miss) and hit=0.
- R2: On a rising clock edge with wr_en=1, slot wr_idx takes all wr_* fields and becomes eligible for matching from the next cycle on. A later write to the same index replaces its contents.
- R3: The lookup key is {va[63:62], va[39:13]}, 29 bits, compared with the stored wr_vpn2 value. Key bit 13+k is excluded from the compare when mask bit k is set. Address bits 61:40 and 12:0 never take part.
- R4: A slot matches only if its global flag is set or its stored tag equals cur_asid.
- R5: When several slots match, the lowest index wins and is reported on hit_idx.
- R6: The offset mask is {mask, 12'hFFF}, zero-extended to 32 bits. The odd frame is chosen when va has a bit set at the position of (offset mask + 1), for example bit 12 for mask 0 and bit 14 for mask 3. Otherwise the even frame is chosen.
- R7: When err=0, pa = (pfn << 12) | (va[31:0] & offset mask), truncated to 32 bits.
- R8: The result codes are: 0 for no error, 1 for miss, 2 for invalid (the selected half has V clear) and 3 for modification (a store to a half with V set and D clear). Invalid takes precedence over modification.
- R9: A load never reports modification. A load to a valid half with D clear returns err=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the write port |
| rst_n | input | 1 | Active-low asynchronous reset; makes all slots ineligible |
| wr_en | input | 1 | Load slot wr_idx on this edge |
| wr_idx | input | 5 | Slot to load |
| wr_mask | input | 12 | Page-size mask field |
| wr_vpn2 | input | 29 | {region[1:0], VPN2[26:0]} |
| wr_asid | input | 8 | Address-space tag |
| wr_global | input | 1 | Match regardless of tag |
| wr_pfn_even | input | 20 | Frame number of the even page |
| wr_v_even | input | 1 | Even page valid |
| wr_d_even | input | 1 | Even page writable |
| wr_pfn_odd | input | 20 | Frame number of the odd page |
| wr_v_odd | input | 1 | Odd page valid |
| wr_d_odd | input | 1 | Odd page writable |
| va | input | 64 | Virtual address to translate |
| is_store | input | 1 | 1 for a store, 0 for a load |
| cur_asid | input | 8 | Current address-space tag |
| hit | output | 1 | Some slot matched |
| hit_idx | output | 5 | Index of the winning slot (meaningful when hit=1) |
| pa | output | 32 | Physical address (meaningful when err=0) |
| err | output | 2 | Result code as listed in R8 |

## Verification
The bench loads three slots. One is a 4 KB tagged mapping, one is a global 16 KB mapping in the top region, and one is a global duplicate of the first. Lookups against the tagged slot with matching and non-matching tags, and with a different region, separate tag matching from region compare. Setting va bit 40 shows that bits outside the key are ignored. Pairs of addresses that differ only in the odd-select bit show which half is used and which valid or dirty flag applies. Loads and stores to those halves separate the invalid, modification and clean cases. The overlapping global slot, first with the tagged one present and then after the tagged one is rewritten, tests the lowest-index rule and overwrite.

// File: rtl/tlb_xlate.sv
module tlb_xlate #(
  parameter int N      = 32,
  parameter int ASID_W = 8,
  parameter int PFN_W  = 20,
  parameter int MASK_W = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [$clog2(N)-1:0] wr_idx,
  input  logic [MASK_W-1:0]    wr_mask,
  input  logic [28:0]          wr_vpn2,
  input  logic [ASID_W-1:0]    wr_asid,
  input  logic                 wr_global,
  input  logic [PFN_W-1:0]     wr_pfn_even,
  input  logic                 wr_v_even,
  input  logic                 wr_d_even,
  input  logic [PFN_W-1:0]     wr_pfn_odd,
  input  logic                 wr_v_odd,
  input  logic                 wr_d_odd,
  input  logic [63:0]          va,
  input  logic                 is_store,
  input  logic [ASID_W-1:0]    cur_asid,
  output logic                 hit,
  output logic [$clog2(N)-1:0] hit_idx,
  output logic [31:0]          pa,
  output logic [1:0]           err
);
  localparam int IDX_W = $clog2(N);
  localparam int KEY_W = 29;
  localparam int OFF_W = 12;

  logic [N-1:0]       vld;
  logic [MASK_W-1:0]  e_mask [N];
  logic [KEY_W-1:0]   e_vpn  [N];
  logic [ASID_W-1:0]  e_asid [N];
  logic [N-1:0]       e_g;
  logic [PFN_W-1:0]   e_pfn0 [N];
  logic [PFN_W-1:0]   e_pfn1 [N];
  logic [N-1:0]       e_v0, e_d0, e_v1, e_d1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     vld <= '0;
    else if (wr_en) vld[wr_idx] <= 1'b1;

  always_ff @(posedge clk)
    if (wr_en) begin
      e_mask[wr_idx] <= wr_mask;
      e_vpn[wr_idx]  <= wr_vpn2;
      e_asid[wr_idx] <= wr_asid;
      e_g[wr_idx]    <= wr_global;
      e_pfn0[wr_idx] <= wr_pfn_even;
      e_v0[wr_idx]   <= wr_v_even;
      e_d0[wr_idx]   <= wr_d_even;
      e_pfn1[wr_idx] <= wr_pfn_odd;
      e_v1[wr_idx]   <= wr_v_odd;
      e_d1[wr_idx]   <= wr_d_odd;
    end

  wire [KEY_W-1:0] va_key = {va[63:62], va[39:13]};
  logic [N-1:0] match, win;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign match[i] = vld[i]
      && (((e_vpn[i] ^ va_key) & ~{{(KEY_W-MASK_W){1'b0}}, e_mask[i]}) == '0)
      && (e_g[i] || (e_asid[i] == cur_asid));
  end

  assign win = match & (~match + 1'b1);
  assign hit = |match;

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < N; i++)
      if (win[i]) hit_idx = hit_idx | IDX_W'(i);
  end

  wire [31:0] omask = {{(32-MASK_W-OFF_W){1'b0}}, e_mask[hit_idx], {OFF_W{1'b1}}};
  wire        odd   = |(va[31:0] & (omask + 32'd1));
  wire [PFN_W-1:0] pfn = odd ? e_pfn1[hit_idx] : e_pfn0[hit_idx];
  wire        sel_v = odd ? e_v1[hit_idx] : e_v0[hit_idx];
  wire        sel_d = odd ? e_d1[hit_idx] : e_d0[hit_idx];

  assign pa = 32'({pfn, {OFF_W{1'b0}}}) | (va[31:0] & omask);

  always_comb begin
    if (!hit)                  err = 2'd1;
    else if (!sel_v)           err = 2'd2;
    else if (is_store && !sel_d) err = 2'd3;
    else                       err = 2'd0;
  end

  a_r1_miss_iff_nohit: assert property (@(posedge clk) disable iff (!rst_n)
    (err == 2'd1) == !hit);
  a_r2_write_enables: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> vld[$past(wr_idx)]);
  a_r5_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (match[hit_idx] && ((match & ((N'(1) << hit_idx) - N'(1))) == '0)));
  a_r7_offset_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (err == 2'd0) |-> ((pa & omask) == (va[31:0] & omask)));
  a_r9_mod_only_store: assert property (@(posedge clk) disable iff (!rst_n)
    (err == 2'd3) |-> is_store);
endmodule

// File: tb/test_tlb_xlate.sv
module test_tlb_xlate;
  logic        clk = 0, rst_n = 0;
  logic        wr_en = 0;
  logic [4:0]  wr_idx = 0;
  logic [11:0] wr_mask = 0;
  logic [28:0] wr_vpn2 = 0;
  logic [7:0]  wr_asid = 0;
  logic        wr_global = 0;
  logic [19:0] wr_pfn_even = 0, wr_pfn_odd = 0;
  logic        wr_v_even = 0, wr_d_even = 0, wr_v_odd = 0, wr_d_odd = 0;
  logic [63:0] va = 0;
  logic        is_store = 0;
  logic [7:0]  cur_asid = 0;
  logic        hit;
  logic [4:0]  hit_idx;
  logic [31:0] pa;
  logic [1:0]  err;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  tlb_xlate i_tlb_xlate (.*);

  // {va, store, asid, err, idx, pa}
  localparam int NV = 12;
  localparam logic [111:0] VEC [NV] = '{
    {64'h0000_0000_0040_0123, 1'b0, 8'd5, 2'd0, 5'd0, 32'h1234_5123}, // R6 even, R7
    {64'h0000_0000_0040_1456, 1'b1, 8'd5, 2'd3, 5'd0, 32'h0},          // R8 modification
    {64'h0000_0000_0040_1456, 1'b0, 8'd5, 2'd0, 5'd0, 32'h2345_6456}, // R9 load ignores D, R6 odd
    {64'h0000_0000_0040_0123, 1'b0, 8'd6, 2'd0, 5'd2, 32'h0ABC_D123}, // R4 tag mismatch -> global slot
    {64'h0000_0000_0040_0123, 1'b0, 8'd5, 2'd0, 5'd0, 32'h1234_5123}, // R5 lowest wins
    {64'h0000_0100_0040_0123, 1'b0, 8'd5, 2'd0, 5'd0, 32'h1234_5123}, // R3 bit 40 ignored
    {64'h4000_0000_0040_0123, 1'b0, 8'd5, 2'd1, 5'd0, 32'h0},          // R3 region differs -> miss
    {64'hC000_0000_1000_6ABC, 1'b1, 8'd9, 2'd0, 5'd1, 32'h0020_2ABC}, // R6 bit 14, R7 16K offset
    {64'hC000_0000_1000_2ABC, 1'b0, 8'd9, 2'd2, 5'd1, 32'h0},          // R8 invalid even
    {64'hC000_0000_1000_2ABC, 1'b1, 8'd9, 2'd2, 5'd1, 32'h0},          // R8 invalid beats mod
    {64'hC000_0000_1000_8ABC, 1'b0, 8'd9, 2'd1, 5'd0, 32'h0},          // R3 bit 15 compared
    {64'h0000_0000_0080_0000, 1'b0, 8'd5, 2'd1, 5'd0, 32'h0}           // R8 miss code
  };

  task automatic load(input int idx, input logic [11:0] m, input logic [28:0] k,
                      input logic [7:0] a, input logic g,
                      input logic [19:0] p0, input logic v0, input logic d0,
                      input logic [19:0] p1, input logic v1, input logic d1);
    @(negedge clk);
    wr_en = 1; wr_idx = 5'(idx); wr_mask = m; wr_vpn2 = k; wr_asid = a; wr_global = g;
    wr_pfn_even = p0; wr_v_even = v0; wr_d_even = d0;
    wr_pfn_odd = p1; wr_v_odd = v1; wr_d_odd = d1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic look(input string req, input logic [63:0] a, input logic st,
                      input logic [7:0] as, input logic [1:0] e,
                      input logic [4:0] ix, input logic [31:0] p);
    @(negedge clk);
    va = a; is_store = st; cur_asid = as;
    #5;
    checks++;
    if (err !== e || (e != 2'd1 && hit_idx !== ix) || (e == 2'd0 && pa !== p)
        || hit !== (e != 2'd1)) begin
      errors++;
      $display("FAIL %s va=%h: err=%0d idx=%0d pa=%h expected err=%0d idx=%0d pa=%h",
               req, a, err, hit_idx, pa, e, ix, p);
    end
  endtask

  initial begin
    #100000000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    look("R1", 64'h0000_0000_0040_0123, 0, 8'd5, 2'd1, 0, 0);
    load(0, 12'h000, 29'h0000200, 8'd5, 0, 20'h12345, 1, 1, 20'h23456, 1, 0);
    load(1, 12'h003, 29'h18008000, 8'd0, 1, 20'h00100, 0, 0, 20'h00200, 1, 1);
    load(2, 12'h000, 29'h0000200, 8'd0, 1, 20'h0ABCD, 1, 1, 20'h0ABCE, 1, 1);
    for (int i = 0; i < NV; i++)
      look("R3-R9 table", VEC[i][111:48], VEC[i][47], VEC[i][46:39],
           VEC[i][38:37], VEC[i][36:32], VEC[i][31:0]);
    // R2: overwrite slot 0 with another tag; tag 5 now falls to slot 2
    load(0, 12'h000, 29'h0000200, 8'd7, 0, 20'h12345, 1, 1, 20'h23456, 1, 0);
    look("R2", 64'h0000_0000_0040_0123, 0, 8'd5, 2'd0, 5'd2, 32'h0ABC_D123);
    look("R2", 64'h0000_0000_0040_0123, 0, 8'd7, 2'd0, 5'd0, 32'h1234_5123);
    // R1: reset again clears all slots
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    look("R1", 64'h0000_0000_0040_0123, 0, 8'd7, 2'd1, 0, 0);
    look("R1", 64'hC000_0000_1000_6ABC, 1, 8'd9, 2'd1, 0, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule